// File: doc/BRIEF.md
# Dual-Rail Token Pipeline

This block is a chain of pipeline stages that carry one-bit data tokens. Each bit is sent on two rails, so an empty link can be told apart from a link that carries a value. Neighbouring stages pass tokens with a four-phase, return-to-zero handshake. The sender puts a value on the rails. The receiver latches it and raises its acknowledge. The sender then returns the rails to empty, and the receiver lowers its acknowledge. A sampling clock drives the whole chain so that it can be synthesized. Every handshake phase therefore resolves on a clock edge.

Each stage holds no more than one token. Two configuration vectors are sampled during reset. They choose, stage by stage, whether a stage starts with a token (and which value) or starts empty. A stage that starts with a token acts like a register in the logical function. A stage that starts empty acts like a repeater: it adds delay but creates no token. The stage that starts empty can still hold tokens later, which lets tokens queue in the chain. An illegal code on the input rails is refused and reported.

Top module: `dr_pipe`

## Requirements
- R1: Rail code as {rail1, rail0}: 2'b01 carries a 0, 2'b10 carries a 1, 2'b00 is empty and 2'b11 is illegal. The downstream rails never show 2'b11.
- R2: A stage holds at most one token. With the downstream acknowledge held low, an empty chain of DEPTH stages accepts exactly DEPTH tokens. It then leaves the upstream acknowledge low while a further token waits on its input.
- R3: The upstream acknowledge rises one clock after a legal token is presented to an empty first stage. It falls only after the upstream rails have returned to empty.
- R4: A stage latches a new token only when it is empty and its downstream acknowledge is low. While its output is valid and the downstream acknowledge stays low, its output rails do not change.
- R5: A stage whose output is valid drives its output rails back to empty in the clock after it samples its downstream acknowledge high.
- R6: When init_hold[i] is set, stage i leaves reset holding the value init_val[i]. When init_hold[i] is clear, stage i leaves reset empty. The last stage's token, if any, appears on the downstream rails during reset.
- R7: Tokens leave in this order: first the initial tokens, from stage DEPTH-1 down to stage 0, then the input tokens in the order they arrived. The chain neither creates nor loses a token, whatever the pace of the downstream acknowledge.
- R8: In an all-empty chain, a token presented upstream appears on the downstream rails after exactly DEPTH clock edges.
- R9: An illegal 2'b11 code upstream is never acknowledged and never enters the chain. rail_err is high in each clock that follows a cycle in which the code was present.
- R10: The synchronous active-high reset holds up_ack and rail_err low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| init_hold | input | DEPTH | Per stage: start holding a token when set |
| init_val | input | DEPTH | Per stage: value of the initial token |
| up_rail0 | input | 1 | Upstream rail that carries a 0 |
| up_rail1 | input | 1 | Upstream rail that carries a 1 |
| up_ack | output | 1 | Acknowledge to the upstream sender |
| dn_rail0 | output | 1 | Downstream rail that carries a 0 |
| dn_rail1 | output | 1 | Downstream rail that carries a 1 |
| dn_ack | input | 1 | Acknowledge from the downstream receiver |
| rail_err | output | 1 | Registered flag: illegal code seen on the upstream rails |

## Verification
The assertions assume that both neighbours follow the four-phase protocol:

- The upstream side keeps a legal code on its rails until up_ack rises. It drops to empty only after that, and presents no new token until up_ack has fallen.
- The downstream side raises dn_ack only while the output rails are valid. It lowers dn_ack only once they are empty.

The stimulus keeps within these rules. Its producer and consumer tasks advance only on the handshake signal they wait for. The single deliberate breach is the illegal 2'b11 code, which the producer holds for several clocks and then withdraws to empty without waiting for an acknowledge.

// File: rtl/dr_pkg.sv
package dr_pkg;

  // Token state stored per stage; the encoding equals the rail pattern {rail1, rail0}.
  typedef enum logic [1:0] {
    TOK_EMPTY = 2'b00,
    TOK_ZERO  = 2'b01,
    TOK_ONE   = 2'b10
  } tok_e;

  function automatic logic rails_valid(input logic [1:0] r);
    return r[0] ^ r[1];
  endfunction

  function automatic logic rails_empty(input logic [1:0] r);
    return ~(r[0] | r[1]);
  endfunction

  function automatic logic rails_illegal(input logic [1:0] r);
    return r[0] & r[1];
  endfunction

  function automatic tok_e init_token(input logic hold, input logic val);
    if (!hold) return TOK_EMPTY;
    return val ? TOK_ONE : TOK_ZERO;
  endfunction

endpackage

// File: rtl/dr_rail_check.sv
module dr_rail_check
  import dr_pkg::*;
(
  input  logic [1:0] rails,
  output logic       is_valid,
  output logic       is_empty
);

  always_comb begin
    is_valid = rails_valid(rails);
    is_empty = rails_empty(rails);
  end

endmodule

// File: rtl/dr_stage.sv
module dr_stage
  import dr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       init_hold,
  input  logic       init_val,
  input  logic [1:0] in_rails,
  output logic       in_ack,
  output logic [1:0] out_rails,
  input  logic       out_ack
);

  tok_e tok_q;
  logic ack_q;
  logic in_valid;
  logic in_empty;
  logic take;

  dr_rail_check u_chk_in (
    .rails    (in_rails),
    .is_valid (in_valid),
    .is_empty (in_empty)
  );

  // Accept only into an empty slot, with the receiver idle and the previous
  // upstream handshake fully returned to zero.
  assign take = (tok_q == TOK_EMPTY) && !out_ack && in_valid && !ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tok_q <= init_token(init_hold, init_val);
      ack_q <= 1'b0;
    end else begin
      if (take) begin
        tok_q <= tok_e'(in_rails);
      end else if ((tok_q != TOK_EMPTY) && out_ack) begin
        tok_q <= TOK_EMPTY;
      end

      if (take) begin
        ack_q <= 1'b1;
      end else if (ack_q && in_empty) begin
        ack_q <= 1'b0;
      end
    end
  end

  assign out_rails = tok_q;
  assign in_ack    = ack_q;

endmodule

// File: rtl/dr_err_flag.sv
module dr_err_flag
  import dr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rails,
  output logic       err
);

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= rails_illegal(rails);
  end

endmodule

// File: rtl/dr_pipe.sv
module dr_pipe #(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEPTH-1:0] init_hold,
  input  logic [DEPTH-1:0] init_val,
  input  logic             up_rail0,
  input  logic             up_rail1,
  output logic             up_ack,
  output logic             dn_rail0,
  output logic             dn_rail1,
  input  logic             dn_ack,
  output logic             rail_err
);

  localparam int NLINK = DEPTH + 1;

  logic [1:0] link_rails [NLINK];
  logic       link_ack   [NLINK];

  assign link_rails[0]     = {up_rail1, up_rail0};
  assign link_ack[DEPTH]   = dn_ack;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      dr_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .init_hold (init_hold[g]),
        .init_val  (init_val[g]),
        .in_rails  (link_rails[g]),
        .in_ack    (link_ack[g]),
        .out_rails (link_rails[g+1]),
        .out_ack   (link_ack[g+1])
      );
    end
  endgenerate

  dr_err_flag u_err (
    .clk   (clk),
    .rst   (rst),
    .rails (link_rails[0]),
    .err   (rail_err)
  );

  assign up_ack   = link_ack[0];
  assign dn_rail0 = link_rails[DEPTH][0];
  assign dn_rail1 = link_rails[DEPTH][1];

endmodule

// File: rtl/dr_pipe_chk.sv
module dr_pipe_chk (
  input logic clk,
  input logic rst,
  input logic up_rail0,
  input logic up_rail1,
  input logic up_ack,
  input logic dn_rail0,
  input logic dn_rail1,
  input logic dn_ack,
  input logic rail_err
);

  logic dn_valid;
  assign dn_valid = dn_rail0 ^ dn_rail1;

  // R1: downstream never carries the illegal code
  assert_out_legal_R1: assert property (@(posedge clk) disable iff (rst)
    !(dn_rail0 && dn_rail1));

  // R4: a valid output waits, unchanged, for the receiver
  assert_out_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ack) |=> $stable({dn_rail1, dn_rail0}));

  // R5: acknowledged output returns to empty next cycle
  assert_out_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && dn_ack) |=> !(dn_rail0 || dn_rail1));

  // R3: acknowledge rises only in answer to a legal token
  assert_ack_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(up_ack) |-> $past(up_rail0 ^ up_rail1));

  // R3: acknowledge falls only after the rails are empty
  assert_ack_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(up_ack) |-> $past(!up_rail0 && !up_rail1));

  // R9: illegal code is never acknowledged and is flagged
  assert_illegal_refused_R9: assert property (@(posedge clk) disable iff (rst)
    (up_rail0 && up_rail1 && !up_ack) |=> (!up_ack && rail_err));

endmodule

bind dr_pipe dr_pipe_chk u_dr_pipe_chk (
  .clk      (clk),
  .rst      (rst),
  .up_rail0 (up_rail0),
  .up_rail1 (up_rail1),
  .up_ack   (up_ack),
  .dn_rail0 (dn_rail0),
  .dn_rail1 (dn_rail1),
  .dn_ack   (dn_ack),
  .rail_err (rail_err)
);

// File: tb/tb_dr_pipe.sv
module tb_dr_pipe;

  localparam int D = 3;

  // Scenario fields: [21:19] hold, [18:16] value, [15:12] count, [11:4] data (bit 0 first), [3:0] ack delay
  localparam int NV = 6;
  localparam logic [21:0] VECS [NV] = '{
    {3'b000, 3'b000, 4'd5, 8'b00010110, 4'd0},
    {3'b111, 3'b101, 4'd3, 8'b00000011, 4'd2},
    {3'b010, 3'b010, 4'd8, 8'hA5,       4'd1},
    {3'b100, 3'b000, 4'd4, 8'b00001001, 4'd3},
    {3'b001, 3'b001, 4'd6, 8'b00000111, 4'd0},
    {3'b110, 3'b100, 4'd2, 8'b00000010, 4'd5}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [D-1:0] init_hold = '0;
  logic [D-1:0] init_val  = '0;
  logic up_rail0 = 1'b0, up_rail1 = 1'b0;
  logic dn_ack = 1'b0;
  logic up_ack, dn_rail0, dn_rail1, rail_err;

  int n_cmp = 0;
  int n_bad = 0;
  logic exp_q [16];
  int   exp_n;

  always #10 clk = ~clk;

  dr_pipe #(.DEPTH(D)) dut (
    .clk(clk), .rst(rst), .init_hold(init_hold), .init_val(init_val),
    .up_rail0(up_rail0), .up_rail1(up_rail1), .up_ack(up_ack),
    .dn_rail0(dn_rail0), .dn_rail1(dn_rail1), .dn_ack(dn_ack),
    .rail_err(rail_err)
  );

  task automatic check(input logic ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic do_reset(input logic [D-1:0] h, input logic [D-1:0] v);
    rst = 1'b1; init_hold = h; init_val = v;
    up_rail0 = 1'b0; up_rail1 = 1'b0; dn_ack = 1'b0;
    repeat (2) @(negedge clk);
    check(up_ack == 1'b0, "R10 up_ack in reset", int'(up_ack), 0);
    check(rail_err == 1'b0, "R10 rail_err in reset", int'(rail_err), 0);
    check({dn_rail1, dn_rail0} == (h[D-1] ? (v[D-1] ? 2'b10 : 2'b01) : 2'b00),
          "R6 last stage reset token", int'({dn_rail1, dn_rail0}),
          int'(h[D-1] ? (v[D-1] ? 2'b10 : 2'b01) : 2'b00));
    rst = 1'b0;
  endtask

  task automatic finish_push();
    while (!up_ack) @(negedge clk);
    up_rail0 = 1'b0; up_rail1 = 1'b0;
    @(negedge clk);
    while (up_ack) @(negedge clk);
  endtask

  task automatic push(input logic b);
    @(negedge clk);
    up_rail0 = ~b; up_rail1 = b;
    finish_push();
  endtask

  task automatic pull(output logic b, input int dly);
    logic [1:0] seen;
    while (!(dn_rail0 ^ dn_rail1)) begin
      check(!(dn_rail0 && dn_rail1), "R1 no illegal output", 3, 0);
      @(negedge clk);
    end
    seen = {dn_rail1, dn_rail0};
    b = dn_rail1;
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      check({dn_rail1, dn_rail0} == seen, "R4 output held", int'({dn_rail1, dn_rail0}), int'(seen));
    end
    dn_ack = 1'b1;
    @(negedge clk);
    check({dn_rail1, dn_rail0} == 2'b00, "R5 cleared after ack", int'({dn_rail1, dn_rail0}), 0);
    dn_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_vec(input logic [21:0] v);
    logic [2:0] h, iv;
    int cnt, dly;
    logic [7:0] data;
    h = v[21:19]; iv = v[18:16]; cnt = int'(v[15:12]); data = v[11:4]; dly = int'(v[3:0]);
    exp_n = 0;
    for (int i = D - 1; i >= 0; i--) if (h[i]) begin exp_q[exp_n] = iv[i]; exp_n++; end
    for (int i = 0; i < cnt; i++) begin exp_q[exp_n] = data[i]; exp_n++; end
    do_reset(h, iv);
    fork
      begin
        for (int i = 0; i < cnt; i++) push(data[i]);
      end
      begin
        for (int i = 0; i < exp_n; i++) begin
          logic b;
          pull(b, dly);
          check(b == exp_q[i], "R7 token order", int'(b), int'(exp_q[i]));
        end
      end
    join
    repeat (3) @(negedge clk);
    check({dn_rail1, dn_rail0} == 2'b00, "R7 no extra token", int'({dn_rail1, dn_rail0}), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic b;
    // Table-driven scenarios: R6, R7, R4, R5
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R8 latency and R3 acknowledge timing through an empty chain
    do_reset('0, '0);
    @(negedge clk);
    up_rail0 = 1'b0; up_rail1 = 1'b1;
    @(negedge clk);
    check(up_ack == 1'b1, "R3 ack one clock after token", int'(up_ack), 1);
    for (int k = 0; k < D - 2; k++) begin
      check({dn_rail1, dn_rail0} == 2'b00, "R8 not yet out", int'({dn_rail1, dn_rail0}), 0);
      @(negedge clk);
    end
    check({dn_rail1, dn_rail0} == 2'b00, "R8 not yet out", int'({dn_rail1, dn_rail0}), 0);
    @(negedge clk);
    check({dn_rail1, dn_rail0} == 2'b10, "R8 out after DEPTH edges", int'({dn_rail1, dn_rail0}), 2);
    check(up_ack == 1'b1, "R3 ack held while rails valid", int'(up_ack), 1);
    up_rail1 = 1'b0;
    @(negedge clk);
    check(up_ack == 1'b0, "R3 ack falls after empty", int'(up_ack), 0);
    pull(b, 0);
    check(b == 1'b1, "R8 value", int'(b), 1);

    // R2 capacity with receiver idle, then drain
    do_reset('0, '0);
    push(1'b0); push(1'b1); push(1'b1);
    @(negedge clk);
    up_rail0 = 1'b1; up_rail1 = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(up_ack == 1'b0, "R2 full chain refuses", int'(up_ack), 0);
    end
    check({dn_rail1, dn_rail0} == 2'b01, "R4 head held while full", int'({dn_rail1, dn_rail0}), 1);
    exp_q[0] = 1'b0; exp_q[1] = 1'b1; exp_q[2] = 1'b1; exp_q[3] = 1'b0;
    fork
      finish_push();
      begin
        for (int i = 0; i < 4; i++) begin
          logic bb;
          pull(bb, 1);
          check(bb == exp_q[i], "R2 drained order", int'(bb), int'(exp_q[i]));
        end
      end
    join

    // R9 illegal code refused and flagged
    do_reset('0, '0);
    @(negedge clk);
    up_rail0 = 1'b1; up_rail1 = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(rail_err == 1'b1, "R9 flag raised", int'(rail_err), 1);
      check(up_ack == 1'b0, "R9 not acknowledged", int'(up_ack), 0);
    end
    check({dn_rail1, dn_rail0} == 2'b00, "R9 nothing entered", int'({dn_rail1, dn_rail0}), 0);
    up_rail0 = 1'b0; up_rail1 = 1'b0;
    @(negedge clk);
    check(rail_err == 1'b0, "R9 flag clears", int'(rail_err), 0);
    repeat (D + 2) @(negedge clk);
    check({dn_rail1, dn_rail0} == 2'b00, "R9 no token created", int'({dn_rail1, dn_rail0}), 0);
    fork
      push(1'b0);
      begin
        pull(b, 0);
        check(b == 1'b0, "R9 next legal token passes", int'(b), 0);
      end
    join

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule